// File: doc/BRIEF.md
# Multi-channel single-edge PWM unit

This block generates up to four pulse-width-modulated outputs from one counter. A prescaler divides the clock into counting steps, and the counter advances by one on each step. Any one of the four compare channels can be named the period channel. When the counter would reach that channel's compare value, it returns to zero instead, and that step begins a new PWM cycle. Every other enabled channel drives an output that is high while the counter is at or above the channel's compare value, so each output is low at the start of a cycle and rises once inside it.

Software programs the unit through a simple write port. The port sets the control bits, the period channel, an enable mask, the prescale divisor and the four compare values. Writing the configuration does not start the unit; a separate write to the run bit does. Compare values written while the unit runs are held in a shadow register and applied at the next cycle start, so no output ever shows a short extra pulse. A build-time option selects a narrow variant in which only channels 0 and 1 can drive outputs.

Top module: `pwm_match_unit`

## Requirements
- R1: After reset the counter reads 0, all outputs are low and the unit is stopped. Writing configuration registers without setting the run bit leaves the counter at 0 and the outputs low.
- R2: Register map on `wr_addr`. Address 0 is control: bit 0 is run and bit 1 holds the counter at zero. Address 1 selects the period channel in bits [1:0]. Address 2 is the enable mask, where bit n enables channel n. Address 3 is the prescale divisor D. Address 4+n is the compare value of channel n.
- R3: While running with a nonzero period value P (the compare value of the period channel), the counter advances once every D+1 clocks. It counts 0, 1, … P-1 and returns to 0 on the step that would reach P, so one cycle lasts P·(D+1) clocks.
- R4: An enabled output channel n, other than the period channel, with compare value M where 0 < M < P, is high exactly while the counter is at least M. It is low from the cycle start until the counter reaches M.
- R5: A compare value of 0 keeps the output high for the whole cycle. A compare value of P or more keeps it low for the whole cycle.
- R6: The period channel's own output, and the output of any channel whose enable bit is clear, stay low.
- R7: In the narrow variant, outputs 2 and 3 stay low whatever their configuration.
- R8: A period value of 0 disables the unit: the counter is held at 0 and all outputs are low even with run set.
- R9: A compare write made while running takes effect at the next cycle start. While stopped, it takes effect on the write's own clock edge.
- R10: Clearing run pauses the unit: the counter keeps its value and the outputs go low. Setting run again resumes counting from the kept value.
- R11: While the hold bit is set, the counter and prescaler are held at 0 and the outputs are low, even with run set. Counting restarts from 0 after the bit is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | CNT_W | Register write data |
| pwm_o | output | 4 | PWM outputs, one per channel |
| count_o | output | CNT_W | Current counter value |

## Verification
The hardest situation to reach is a compare write that lands in the middle of a running cycle. To check it, the bench must tell the old value from the new one on the exact step where the cycle ends. The bench waits for a known value on `count_o`, then issues the write on the next edge. It checks each later sample against the old threshold until it sees the counter return to zero, and against the new threshold after that. Pause and resume from a nonzero count are reached in the same way, by stopping on an observed count, so both the held value and the first step after resuming are known in advance.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int NUM_CH = 4;
  localparam int SEL_W  = 2;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_CTRL       = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_PSEL       = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_ENA        = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_PRE        = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_MATCH_BASE = 3'd4;

  typedef struct packed {
    logic run;
    logic hold;
  } ctrl_t;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs import pwm_pkg::*; #(
  parameter int CNT_W = 32,
  parameter int PRE_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  logic [CNT_W-1:0]              wr_data,
  input  logic                          load_act,
  output ctrl_t                         ctrl_o,
  output logic [SEL_W-1:0]              psel_o,
  output logic [NUM_CH-1:0]             ena_o,
  output logic [PRE_W-1:0]              pre_o,
  output logic [NUM_CH-1:0][CNT_W-1:0]  match_o
);
  ctrl_t              ctrl_q, ctrl_d;
  logic [SEL_W-1:0]   psel_q, psel_d;
  logic [NUM_CH-1:0]  ena_q,  ena_d;
  logic [PRE_W-1:0]   pre_q,  pre_d;

  // next-state for the direct control fields
  always_comb begin
    ctrl_d = ctrl_q;
    psel_d = psel_q;
    ena_d  = ena_q;
    pre_d  = pre_q;
    if (wr_en) begin
      case (wr_addr)
        ADDR_CTRL: begin
          ctrl_d.run  = wr_data[0];
          ctrl_d.hold = wr_data[1];
        end
        ADDR_PSEL: psel_d = wr_data[SEL_W-1:0];
        ADDR_ENA:  ena_d  = wr_data[NUM_CH-1:0];
        ADDR_PRE:  pre_d  = wr_data[PRE_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      psel_q <= '0;
      ena_q  <= '0;
      pre_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      psel_q <= psel_d;
      ena_q  <= ena_d;
      pre_q  <= pre_d;
    end
  end

  assign ctrl_o = ctrl_q;
  assign psel_o = psel_q;
  assign ena_o  = ena_q;
  assign pre_o  = pre_q;

  // per-channel shadow and active compare registers
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_match
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_MATCH_BASE + ADDR_W'(ch);
    logic [CNT_W-1:0] shadow_q, shadow_d;
    logic [CNT_W-1:0] act_q, act_d;
    logic             shadow_we;

    assign shadow_we = wr_en && (wr_addr == MY_ADDR);

    always_comb begin
      shadow_d = shadow_we ? wr_data : shadow_q;
      act_d    = load_act ? shadow_d : act_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shadow_q <= '0;
        act_q    <= '0;
      end else begin
        shadow_q <= shadow_d;
        act_q    <= act_d;
      end
    end

    assign match_o[ch] = act_q;
  end
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int CNT_W = 32,
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             hold,
  input  logic [PRE_W-1:0] pre,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] cnt_o,
  output logic             tick_o,
  output logic             wrap_o,
  output logic             live_o
);
  logic [PRE_W-1:0] pc_q, pc_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W:0]   cnt_inc;
  logic             period_ok, live, pc_end, tick, wrap;

  always_comb begin
    period_ok = (period != '0);
    live      = run && !hold && period_ok;
    pc_end    = (pc_q >= pre);
    tick      = live && pc_end;
    cnt_inc   = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
    // wrap on >= so a stale count above a newly lowered period recovers
    wrap      = tick && (cnt_inc >= {1'b0, period});

    if (hold || !period_ok) begin
      pc_d = '0;
    end else if (run) begin
      pc_d = pc_end ? '0 : pc_q + PRE_W'(1);
    end else begin
      pc_d = pc_q;
    end

    if (hold || !period_ok) begin
      cnt_d = '0;
    end else if (wrap) begin
      cnt_d = '0;
    end else if (tick) begin
      cnt_d = cnt_inc[CNT_W-1:0];
    end else begin
      cnt_d = cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      cnt_q <= '0;
    end else begin
      pc_q  <= pc_d;
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign tick_o = tick;
  assign wrap_o = wrap;
  assign live_o = live;
endmodule

// File: rtl/pwm_out_stage.sv
module pwm_out_stage import pwm_pkg::*; #(
  parameter int CNT_W   = 32,
  parameter int NUM_OUT = 4
) (
  input  logic [CNT_W-1:0]             cnt,
  input  logic [NUM_CH-1:0][CNT_W-1:0] match,
  input  logic [NUM_CH-1:0]            ena,
  input  logic [SEL_W-1:0]             psel,
  input  logic                         live,
  output logic [NUM_CH-1:0]            pwm_o
);
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    if (ch < NUM_OUT) begin : g_drv
      logic is_period;
      assign is_period = (psel == SEL_W'(ch));
      assign pwm_o[ch] = live && ena[ch] && !is_period && (cnt >= match[ch]);
    end else begin : g_off
      assign pwm_o[ch] = 1'b0;
    end
  end
endmodule

// File: rtl/pwm_match_unit.sv
module pwm_match_unit import pwm_pkg::*; #(
  parameter int CNT_W  = 32,
  parameter int PRE_W  = 8,
  parameter bit NARROW = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  output logic [NUM_CH-1:0] pwm_o,
  output logic [CNT_W-1:0]  count_o
);
  localparam int NUM_OUT = NARROW ? 2 : NUM_CH;

  // asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  ctrl_t                        ctrl_w;
  logic [SEL_W-1:0]             psel_w;
  logic [NUM_CH-1:0]            ena_w;
  logic [PRE_W-1:0]             pre_w;
  logic [NUM_CH-1:0][CNT_W-1:0] match_w;
  logic [CNT_W-1:0]             period_w;
  logic                         run_w, hold_w, tick_w, wrap_w, live_w, load_act_w;

  assign run_w    = ctrl_w.run;
  assign hold_w   = ctrl_w.hold;
  assign period_w = match_w[psel_w];
  // active compare values follow the shadows whenever not mid-cycle
  assign load_act_w = !run_w || hold_w || (period_w == '0) || wrap_w;

  pwm_regs #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .load_act (load_act_w),
    .ctrl_o   (ctrl_w),
    .psel_o   (psel_w),
    .ena_o    (ena_w),
    .pre_o    (pre_w),
    .match_o  (match_w)
  );

  pwm_timebase #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_tb (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .run    (run_w),
    .hold   (hold_w),
    .pre    (pre_w),
    .period (period_w),
    .cnt_o  (count_o),
    .tick_o (tick_w),
    .wrap_o (wrap_w),
    .live_o (live_w)
  );

  pwm_out_stage #(.CNT_W(CNT_W), .NUM_OUT(NUM_OUT)) u_out (
    .cnt   (count_o),
    .match (match_w),
    .ena   (ena_w),
    .psel  (psel_w),
    .live  (live_w),
    .pwm_o (pwm_o)
  );
endmodule

// File: rtl/pwm_match_unit_chk.sv
module pwm_match_unit_chk import pwm_pkg::*; #(
  parameter int CNT_W  = 32,
  parameter bit NARROW = 1'b0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run,
  input logic              hold,
  input logic              tick,
  input logic [SEL_W-1:0]  psel,
  input logic [CNT_W-1:0]  period,
  input logic [CNT_W-1:0]  count,
  input logic [NUM_CH-1:0] pwm
);
  assert_hold_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (count == '0));

  assert_idle_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!run || hold) |-> (pwm == '0));

  assert_pause_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !hold && period != '0) |=> $stable(count));

  assert_zero_period_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (period == '0) |=> (count == '0));

  assert_zero_period_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (period == '0) |-> (pwm == '0));

  assert_period_chan_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (pwm[psel] == 1'b0));

  assert_wrap_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && period != '0) |=> (count < $past(period)));

  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !hold) |=> (count == '0 || count == $past(count) + CNT_W'(1)));

  if (NARROW) begin : g_narrow
    assert_narrow_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (pwm[NUM_CH-1:2] == '0));
  end
endmodule

bind pwm_match_unit pwm_match_unit_chk #(.CNT_W(CNT_W), .NARROW(NARROW)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n_s),
  .run    (run_w),
  .hold   (hold_w),
  .tick   (tick_w),
  .psel   (psel_w),
  .period (period_w),
  .count  (count_o),
  .pwm    (pwm_o)
);

// File: tb/tb_pwm_match_unit.sv
`timescale 1ns/1ps
module tb_pwm_match_unit;
  localparam int CW = 6;
  localparam int PW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [2:0]    wr_addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic [3:0]    pwm_w, pwm_n;
  logic [CW-1:0] cnt_w, cnt_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pwm_match_unit #(.CNT_W(CW), .PRE_W(PW), .NARROW(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_o(pwm_w), .count_o(cnt_w));

  pwm_match_unit #(.CNT_W(CW), .PRE_W(PW), .NARROW(1'b1)) dut_n (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_o(pwm_n), .count_o(cnt_n));

  task automatic chk(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // called at a falling edge; returns at the falling edge after the write edge
  task automatic wr(input int a, input int d);
    wr_en   = 1'b1;
    wr_addr = 3'(a);
    wr_data = CW'(d);
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic string tag_of(input int ch, input int sel, input logic [3:0] en,
                                   input int m, input int p, input bit narrow);
    if (narrow && ch >= 2)         return "R7";
    if (ch == sel || !en[ch])      return "R6";
    if (m == 0 || m >= p)          return "R5";
    return "R4";
  endfunction

  task automatic check_outputs(input int c, input int p, input int sel,
                               input logic [3:0] en, input int m [4]);
    for (int ch = 0; ch < 4; ch++) begin
      int hi_w, hi_n;
      hi_w = (ch != sel && en[ch] && c >= m[ch]) ? 1 : 0;
      hi_n = (ch < 2) ? hi_w : 0;
      chk(tag_of(ch, sel, en, m[ch], p, 1'b0), int'(pwm_w[ch]), hi_w, $sformatf("wide out%0d", ch));
      chk(tag_of(ch, sel, en, m[ch], p, 1'b1), int'(pwm_n[ch]), hi_n, $sformatf("narrow out%0d", ch));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int m [4];
    logic [3:0] en;
    int sel;
    int held;
    bit seen_wrap;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state, then configuration alone does not start counting
    chk("R1", int'(cnt_w), 0, "count after reset");
    chk("R1", int'(pwm_w), 0, "outputs after reset");
    wr(2, 15); wr(1, 3); wr(7, 5); wr(4, 0); wr(5, 0);
    for (int i = 0; i < 8; i++) begin
      chk("R1", int'(cnt_w), 0, "count configured but not run");
      chk("R1", int'(pwm_w), 0, "outputs configured but not run");
      @(negedge clk);
    end

    // R2: enable mask bit n drives channel n
    wr(0, 2); wr(4, 0); wr(5, 0); wr(6, 0); wr(7, 5); wr(1, 3); wr(3, 0);
    wr(2, 4'b0010); wr(0, 1);
    chk("R2", int'(pwm_w), 4'b0010, "mask 0010 wide");
    chk("R2", int'(pwm_n), 4'b0010, "mask 0010 narrow");
    wr(2, 4'b0100);
    chk("R2", int'(pwm_w), 4'b0100, "mask 0100 wide");
    chk("R2", int'(pwm_n), 4'b0000, "mask 0100 narrow");

    // sweep over period, prescale and compare values
    for (int p = 1; p <= 6; p++) begin
      for (int d = 0; d <= 2; d++) begin
        for (int mv = 0; mv <= p + 1; mv++) begin
          int j;
          sel = (p + d) % 4;
          j = 0;
          for (int ch = 0; ch < 4; ch++) begin
            if (ch == sel) m[ch] = p;
            else begin
              case (j)
                0: m[ch] = mv;
                1: m[ch] = (mv <= p) ? p - mv : 0;
                default: m[ch] = mv + 1;
              endcase
              j++;
            end
          end
          en = (mv % 3 == 2) ? (4'hF & ~(4'b0001 << ((sel + 1) % 4))) : 4'hF;
          wr(0, 2); wr(3, d); wr(1, sel); wr(2, int'(en));
          for (int ch = 0; ch < 4; ch++) wr(4 + ch, m[ch]);
          wr(0, 1);
          for (int k = 0; k <= 2 * p * (d + 1); k++) begin
            int c;
            c = (k / (d + 1)) % p;
            chk("R3", int'(cnt_w), c, "wide count");
            chk("R3", int'(cnt_n), c, "narrow count");
            check_outputs(c, p, sel, en, m);
            @(negedge clk);
          end
        end
      end
    end

    // R8: a zero period keeps the unit idle
    wr(0, 2); wr(3, 0); wr(1, 3); wr(2, 15); wr(7, 0); wr(4, 0); wr(0, 1);
    for (int i = 0; i < 8; i++) begin
      chk("R8", int'(cnt_w), 0, "count with zero period");
      chk("R8", int'(pwm_w), 0, "wide outputs with zero period");
      chk("R8", int'(pwm_n), 0, "narrow outputs with zero period");
      @(negedge clk);
    end

    // R9: compare write mid-cycle applies at the next cycle start
    wr(0, 2); wr(2, 1); wr(7, 8); wr(4, 2); wr(0, 1);
    while (cnt_w != 4) @(negedge clk);
    wr(4, 6);
    seen_wrap = 1'b0;
    for (int i = 0; i < 16; i++) begin
      if (cnt_w == 0) seen_wrap = 1'b1;
      chk("R9", int'(pwm_w[0]), (int'(cnt_w) >= (seen_wrap ? 6 : 2)) ? 1 : 0, "out0 around update");
      @(negedge clk);
    end
    chk("R9", int'(seen_wrap), 1, "cycle boundary seen");

    // R10: pause keeps the count, outputs low, resume continues
    while (cnt_w != 3) @(negedge clk);
    wr(0, 0);
    held = int'(cnt_w);
    chk("R10", held, 4, "count at pause");
    for (int i = 0; i < 6; i++) begin
      chk("R10", int'(cnt_w), held, "count while paused");
      chk("R10", int'(pwm_w), 0, "outputs while paused");
      @(negedge clk);
    end
    wr(0, 1);
    chk("R10", int'(cnt_w), held, "count on resume edge");
    @(negedge clk);
    chk("R10", int'(cnt_w), held + 1, "count after resume");

    // R11: hold forces zero even with run set
    wr(0, 3);
    @(negedge clk);
    for (int i = 0; i < 6; i++) begin
      chk("R11", int'(cnt_w), 0, "count while held");
      chk("R11", int'(pwm_w), 0, "outputs while held");
      @(negedge clk);
    end
    wr(0, 1);
    chk("R11", int'(cnt_w), 0, "count on release edge");
    @(negedge clk);
    chk("R11", int'(cnt_w), 1, "count after release");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule